// File: doc/BRIEF.md
# Interlocked Request/Acknowledge Bus Pair

This block pairs a bus master sequencer with a slave responder that talk over a fully interlocked four-edge request/acknowledge handshake. Both halves sit in one clock domain, but each treats the handshake line coming from the other side as if it were unclocked: the line passes through a two-flop synchronizer before any decision is made on it. That gives a fixed, predictable round trip, and each half can later be split off into a separate timing domain.

A client hands the master one job at a time: read or write, a word address and, for a write, a data word. The master puts the direction, address and data on the bus and waits a configurable number of cycles so that a decoder can settle. Then it cycles the request line. The slave is a small register file. On request it stores the write word, or it loads the addressed word onto the read-data lines, and then raises acknowledge. Both lines then return to low in turn. A job can only start once the whole exchange has wound down, so jobs can be issued back to back without overlap.

Top module: `hsb_pair`

## Requirements
- R1: While reset is held and on the first cycle after it, `bus_req`, `bus_ack` and `job_done` are low and `job_ready` is high. All slave words reset to zero.
- R2: A job is taken only on a clock edge where `job_valid` and `job_ready` are both high. `job_ready` is high only when the master is idle, its request is low and its synchronized view of acknowledge is low. A job offered while `job_ready` is low has no effect.
- R3: `bus_write` (1 = write, 0 = read), `bus_addr` and `bus_wdata` take the job's values on the accepting edge. They hold those values until the next accepted job.
- R4: `bus_req` rises exactly SETTLE cycles after the accepting edge. It rises only while `bus_ack` is low.
- R5: `bus_ack` rises 3 cycles after `bus_req` rises: two synchronizer stages plus the response register. On that same edge a write stores `bus_wdata` into the word at `bus_addr`, and a read loads that word onto `bus_rdata`.
- R6: `bus_req` falls 3 cycles after `bus_ack` rises. On that edge `job_done` is high for exactly one cycle.
- R7: `bus_ack` falls 3 cycles after `bus_req` falls, and never while `bus_req` is high.
- R8: `job_ready` rises again SETTLE+12 cycles after the accepting edge.
- R9: On a read, `rd_data` is captured when `job_done` goes high. It holds the addressed word and keeps that value until the next read completes. Writes leave it unchanged.
- R10: A read returns the last word written to that address, or zero if nothing has been written there. This holds at the lowest and the highest address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| job_valid | input | 1 | Client offers a job |
| job_write | input | 1 | 1 = write, 0 = read |
| job_addr | input | ADDR_W | Word address of the job |
| job_wdata | input | DATA_W | Write data of the job |
| job_ready | output | 1 | Master idle and able to accept a job |
| job_done | output | 1 | One-cycle pulse when the master drops request |
| rd_data | output | DATA_W | Data returned by the last read |
| bus_req | output | 1 | Request line, master to slave |
| bus_ack | output | 1 | Acknowledge line, slave to master |
| bus_addr | output | ADDR_W | Address on the bus |
| bus_write | output | 1 | Direction on the bus |
| bus_wdata | output | DATA_W | Write data on the bus |
| bus_rdata | output | DATA_W | Read data driven by the slave |

## Verification
The bench builds the pair with SETTLE=3, a 4-bit address and 8-bit data. A settle delay above the default and above 1 tests that the wait counter really counts, not just waits one cycle. The whole register file is only sixteen words, so both ends of the address range can be written and read back, and untouched words can be checked for their reset value. Every handshake edge, the done pulse and the return of `job_ready` are predicted by a reference model in the bench, which counts cycles from the accepting edge.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    M_IDLE   = 2'd0,
    M_SETTLE = 2'd1,
    M_REQ    = 2'd2,
    M_DRAIN  = 2'd3
  } hsb_mst_e;

  // each of the four edges crosses a synchronizer and one register
  function automatic int unsigned hsb_round_trip(input int unsigned settle);
    return settle + 4 * (SYNC_DEPTH + 1);
  endfunction
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hsb_master.sv
module hsb_master
  import hsb_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SETTLE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              job_valid,
  input  logic              job_write,
  input  logic [ADDR_W-1:0] job_addr,
  input  logic [DATA_W-1:0] job_wdata,
  output logic              job_ready,
  output logic              job_done,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ack_seen,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_req,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              accept_evt
);
  localparam int unsigned CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  hsb_mst_e      state;
  logic [CW-1:0] cnt;

  assign job_ready  = (state == M_IDLE) && !ack_seen;
  assign accept_evt = job_valid && job_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= M_IDLE;
      cnt       <= '0;
      bus_req   <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      job_done  <= 1'b0;
      rd_data   <= '0;
    end else begin
      job_done <= 1'b0;
      unique case (state)
        M_IDLE: if (accept_evt) begin
          bus_write <= job_write;
          bus_addr  <= job_addr;
          bus_wdata <= job_wdata;
          cnt       <= '0;
          state     <= M_SETTLE;
        end
        M_SETTLE: if (cnt == LAST) begin
          bus_req <= 1'b1;
          state   <= M_REQ;
        end else begin
          cnt <= cnt + 1'b1;
        end
        M_REQ: if (ack_seen) begin
          bus_req  <= 1'b0;
          job_done <= 1'b1;
          if (!bus_write) rd_data <= bus_rdata;
          state    <= M_DRAIN;
        end
        M_DRAIN: if (!ack_seen) state <= M_IDLE;
        default: state <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hsb_slave.sv
module hsb_slave #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_seen,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (req_seen && !bus_ack) begin
      if (bus_write) words[bus_addr] <= bus_wdata;
      else           bus_rdata       <= words[bus_addr];
      bus_ack <= 1'b1;
    end else if (!req_seen && bus_ack) begin
      bus_ack <= 1'b0;
    end
  end
endmodule

// File: rtl/hsb_pair.sv
module hsb_pair
  import hsb_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SETTLE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              job_valid,
  input  logic              job_write,
  input  logic [ADDR_W-1:0] job_addr,
  input  logic [DATA_W-1:0] job_wdata,
  output logic              job_ready,
  output logic              job_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_req,
  output logic              bus_ack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic req_seen;
  logic ack_seen;
  logic accept_evt;

  hsb_sync #(.STAGES(SYNC_DEPTH)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_req), .q(req_seen)
  );

  hsb_sync #(.STAGES(SYNC_DEPTH)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_ack), .q(ack_seen)
  );

  hsb_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE(SETTLE)) u_mst (
    .clk(clk), .rst_n(rst_n),
    .job_valid(job_valid), .job_write(job_write), .job_addr(job_addr),
    .job_wdata(job_wdata), .job_ready(job_ready), .job_done(job_done),
    .rd_data(rd_data), .ack_seen(ack_seen), .bus_rdata(bus_rdata),
    .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .accept_evt(accept_evt)
  );

  hsb_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slv (
    .clk(clk), .rst_n(rst_n), .req_seen(req_seen),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/hsb_pair_chk.sv
module hsb_pair_chk
  import hsb_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SETTLE = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              job_ready,
  input logic              job_done,
  input logic              bus_req,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_write,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              accept_evt
);
  logic [15:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             since <= '0;
    else if (accept_evt)    since <= '0;
    else if (since != '1)   since <= since + 1'b1;
  end

  AST_ACCEPT_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> (!bus_req && !bus_ack)) else $error("accept while busy"); // R2
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!job_ready && $past(!job_ready)) |-> ($stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)))
    else $error("fields moved"); // R3
  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> (since == 16'(SETTLE) && !bus_ack)) else $error("settle gap"); // R4
  AST_ACK_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> bus_req) else $error("ack without req"); // R5
  AST_REQ_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> (bus_ack && job_done)) else $error("req fell early"); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |=> !job_done) else $error("done too long"); // R6
  AST_ACK_DROP_ON_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack) |-> !bus_req) else $error("ack fell early"); // R7
  AST_READY_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(job_ready) |-> (since == 16'(hsb_round_trip(SETTLE)))) else $error("ready timing"); // R8
endmodule

bind hsb_pair hsb_pair_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE(SETTLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .job_ready(job_ready), .job_done(job_done),
  .bus_req(bus_req), .bus_ack(bus_ack), .bus_addr(bus_addr),
  .bus_write(bus_write), .bus_wdata(bus_wdata), .accept_evt(accept_evt)
);

// File: tb/sim_hsb_pair.sv
`timescale 1ns/1ps
module sim_hsb_pair;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int S  = 3;
  localparam int TRIP = S + 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic job_valid = 1'b0, job_write = 1'b0;
  logic [AW-1:0] job_addr = '0;
  logic [DW-1:0] job_wdata = '0;
  logic job_ready, job_done, bus_req, bus_ack, bus_write;
  logic [DW-1:0] rd_data, bus_wdata, bus_rdata;
  logic [AW-1:0] bus_addr;

  always #2.5 clk = ~clk;

  hsb_pair #(.ADDR_W(AW), .DATA_W(DW), .SETTLE(S)) u0 (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_write(job_write),
    .job_addr(job_addr), .job_wdata(job_wdata), .job_ready(job_ready),
    .job_done(job_done), .rd_data(rd_data), .bus_req(bus_req), .bus_ack(bus_ack),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int ref_mem [16];
  bit busy = 0;
  int ph = 0;
  bit cur_wr = 0;
  int cur_addr = 0, cur_data = 0, exp_rd = 0, jobs = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (busy) begin
        ph++;
        if (ph == TRIP) busy = 0;
      end else if (job_valid) begin
        busy = 1; ph = 0; jobs++;
        cur_wr = job_write; cur_addr = int'(job_addr); cur_data = int'(job_wdata);
        if (cur_wr) ref_mem[cur_addr] = cur_data;
        else        exp_rd = ref_mem[cur_addr];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && jobs > 0) begin
      bit e_req, e_ack, e_done;
      e_req  = busy && ph >= S && ph < S + 6;
      e_ack  = busy && ph >= S + 3 && ph < S + 9;
      e_done = busy && ph == S + 6;
      chk(bus_req == e_req, "R4/R6 bus_req", int'(bus_req), int'(e_req));
      chk(bus_ack == e_ack, "R5/R7 bus_ack", int'(bus_ack), int'(e_ack));
      chk(job_done == e_done, "R6 job_done", int'(job_done), int'(e_done));
      chk(job_ready == !busy, "R2/R8 job_ready", int'(job_ready), int'(!busy));
      chk(int'(bus_addr) == cur_addr && bus_write == cur_wr,
          "R3 bus_addr/bus_write", int'({bus_write, bus_addr}), int'({cur_wr, 4'(cur_addr)}));
      if (cur_wr)
        chk(int'(bus_wdata) == cur_data, "R3 bus_wdata", int'(bus_wdata), cur_data);
      if (!busy || ph >= S + 6)
        if (!cur_wr)
          chk(int'(rd_data) == exp_rd, "R9 R10 rd_data", int'(rd_data), exp_rd);
    end
  end

  task automatic job(input bit w, input int a, input int d);
    @(negedge clk); #1;
    while (!job_ready) begin @(negedge clk); #1; end
    job_valid = 1; job_write = w; job_addr = AW'(a); job_wdata = DW'(d);
    @(negedge clk); #1;
    job_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk); #1;
    while (!job_ready) begin @(negedge clk); #1; end
  endtask

  int cycles = 0;
  bit timed_out = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !timed_out) begin
      timed_out = 1;
      chk(0, "watchdog", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = 0;
    repeat (3) @(negedge clk);
    // R1: during reset
    chk(!bus_req && !bus_ack && !job_done && job_ready, "R1 reset outputs",
        int'({bus_req, bus_ack, job_done, job_ready}), 1);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_req && !bus_ack && !job_done && job_ready, "R1 after reset",
        int'({bus_req, bus_ack, job_done, job_ready}), 1);
    // R10: untouched words read zero at both ends
    job(0, 0, 0);
    job(0, 15, 0);
    // writes then reads, edge data values
    job(1, 0, 8'hFF);
    job(1, 15, 8'h00);
    job(1, 7, 8'hA5);
    job(0, 0, 0);
    job(1, 3, 8'h3C);
    job(0, 7, 0);
    job(0, 15, 0);
    // R9: rd_data held across a write
    job(1, 9, 8'h5A);
    wait_idle();
    chk(rd_data == 8'h00, "R9 hold across write", int'(rd_data), 0);
    // R2: offers while busy are ignored
    job(1, 4, 8'h11);
    job_valid = 1; job_write = 1; job_addr = 4'd4; job_wdata = 8'h99;
    repeat (5) @(negedge clk);
    #1 job_valid = 0;
    job(0, 4, 0);
    wait_idle();
    chk(rd_data == 8'h11, "R2 busy offer ignored", int'(rd_data), 8'h11);
    // back to back with valid held
    @(negedge clk); #1;
    job_valid = 1; job_write = 0; job_addr = 4'd3;
    repeat (3 * TRIP + 4) @(negedge clk);
    #1 job_valid = 0;
    wait_idle();
    chk(rd_data == 8'h3C, "R10 back-to-back read", int'(rd_data), 8'h3C);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule